// File: doc/BRIEF.md
# Block Address Translation Lookup

This block translates an effective address into a real address through a small set of software-programmed address windows. It holds eight windows for instruction fetches and a separate eight for data accesses. Each window carries an effective-page base, a mask that sets the window size, a real-page base, separate enable bits for supervisor and user state, and a 2-bit protection code.

A request presents the effective address, an instruction/data select, the privilege state and a write flag. The block searches the selected set from the lowest index upward, all in one combinational pass. The first window that is enabled, matches and grants the access wins. A window that matches but refuses the access is passed over, and the search goes on. One cycle later the block registers a hit flag, the real address and read/write/execute rights. It holds them until the next request. Software loads one whole window per cycle through a write port.

Top module: `bat_xlate_top`

## Requirements
- R1: After reset, every window enable is clear, all response outputs are 0, and a lookup misses until a window is programmed.
- R2: `req_dside`=1 searches only the data set and `req_dside`=0 only the instruction set. The write port uses the same encoding on `cfg_dside`.
- R3: A window takes part only if its user enable is set when `req_user`=1, or its supervisor enable is set when `req_user`=0.
- R4: A window matches when `(req_ea & mask) == ea_base`. Software keeps the base aligned to the mask; the hardware does not check this.
- R5: On a hit, the real address is the winning window's real base ORed with the bits of `req_ea` that its mask clears.
- R6: On a hit, read is granted for protection codes 1, 2 and 3, write is granted for codes 2 and 3, and execute is always granted.
- R7: A matching window with protection code 0, or with code 1 during a write, is skipped, and higher-numbered windows are still considered.
- R8: When several windows qualify, the one with the lowest index wins.
- R9: `rsp_valid` pulses for one cycle, in the cycle after the cycle in which `req_valid` is sampled high. The other response outputs update in that same cycle and stay unchanged while no request is made.
- R10: When no window qualifies, the response shows `rsp_hit`=0, a real address of 0 and all rights at 0.
- R11: A window written in cycle N is used by requests sampled from cycle N+1 on. A request sampled in cycle N sees the window's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one window |
| cfg_dside | input | 1 | Target set: 1 data, 0 instruction |
| cfg_idx | input | 3 | Window index to write |
| cfg_ea_base | input | 32 | Effective-page base |
| cfg_ea_mask | input | 32 | Compare mask |
| cfg_ra_base | input | 32 | Real-page base |
| cfg_sup_en | input | 1 | Window enabled in supervisor state |
| cfg_usr_en | input | 1 | Window enabled in user state |
| cfg_prot | input | 2 | Protection code |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_dside | input | 1 | Set to search: 1 data, 0 instruction |
| req_user | input | 1 | 1 user state, 0 supervisor state |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | A window qualified |
| rsp_real | output | 32 | Translated real address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |

## Verification
The bench sets up windows that overlap. A design that stopped at the first matching window would then answer with a refused window or fault outright, instead of reaching a later window with a different real base. Some requests go to the set the other select would search, or use the privilege state whose enable is clear. A design that mixed up the sets or the enables would return the wrong real base or a hit where a miss belongs. A window is rewritten in the same cycle as a request, so a design that bypassed new window contents into the current lookup would answer early. Idle cycles between requests catch outputs that do not hold their value, and a long pseudo-random run compares every cycle against a behavioural model.

// File: rtl/bat_pkg.sv
package bat_pkg;

  localparam int BAT_AW = 32;

  typedef struct packed {
    logic [BAT_AW-1:0] ea_base;
    logic [BAT_AW-1:0] ea_mask;
    logic [BAT_AW-1:0] ra_base;
    logic              sup_en;
    logic              usr_en;
    logic [1:0]        prot;
  } bat_win_t;

  // window takes part for this privilege state
  function automatic logic win_enabled(bat_win_t w, logic user);
    return user ? w.usr_en : w.sup_en;
  endfunction

  function automatic logic win_match(bat_win_t w, logic [BAT_AW-1:0] ea);
    return (ea & w.ea_mask) == w.ea_base;
  endfunction

  function automatic logic [BAT_AW-1:0] win_real(bat_win_t w, logic [BAT_AW-1:0] ea);
    return w.ra_base | (ea & ~w.ea_mask);
  endfunction

  function automatic logic prot_read(logic [1:0] p);
    return p != 2'd0;
  endfunction

  function automatic logic prot_write(logic [1:0] p);
    return p > 2'd1;
  endfunction

endpackage

// File: rtl/bat_bank.sv
module bat_bank
  import bat_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter bit SIDE   = 1'b0,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  side,
  input  logic [IDX_W-1:0]      idx,
  input  bat_win_t              wdata,
  output bat_win_t [N_ENT-1:0]  wins
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_win
    logic sel;
    assign sel = we && (side == SIDE) && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wins[i] <= '0;
      end else if (sel) begin
        wins[i] <= wdata;
      end
    end
  end

endmodule

// File: rtl/bat_search.sv
module bat_search
  import bat_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  bat_win_t [N_ENT-1:0] wins,
  input  logic [BAT_AW-1:0]    ea,
  input  logic                 user,
  input  logic                 write,
  output logic [N_ENT-1:0]     qual,
  output logic [N_ENT-1:0]     win_oh,
  output logic                 hit,
  output logic [BAT_AW-1:0]    real_addr,
  output logic                 rd,
  output logic                 wr
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_q
    logic en, mt, ok;
    assign en = win_enabled(wins[i], user);
    assign mt = win_match(wins[i], ea);
    assign ok = prot_read(wins[i].prot) && (!write || prot_write(wins[i].prot));
    assign qual[i] = en && mt && ok;
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      win_oh[i] = qual[i] && !seen;
      seen      = seen || qual[i];
    end
  end

  assign hit = |qual;

  always_comb begin
    real_addr = '0;
    rd        = 1'b0;
    wr        = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (win_oh[i]) begin
        real_addr = real_addr | win_real(wins[i], ea);
        rd        = rd | prot_read(wins[i].prot);
        wr        = wr | prot_write(wins[i].prot);
      end
    end
  end

endmodule

// File: rtl/bat_xlate_top.sv
module bat_xlate_top
  import bat_pkg::*;
#(
  parameter int N_ENT   = 8,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int AW     = BAT_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_dside,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [AW-1:0]    cfg_ea_base,
  input  logic [AW-1:0]    cfg_ea_mask,
  input  logic [AW-1:0]    cfg_ra_base,
  input  logic             cfg_sup_en,
  input  logic             cfg_usr_en,
  input  logic [1:0]       cfg_prot,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_ea,
  input  logic             req_dside,
  input  logic             req_user,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [AW-1:0]    rsp_real,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex
);

  bat_win_t wdata;
  assign wdata = '{ea_base: cfg_ea_base, ea_mask: cfg_ea_mask, ra_base: cfg_ra_base,
                   sup_en: cfg_sup_en, usr_en: cfg_usr_en, prot: cfg_prot};

  bat_win_t [1:0][N_ENT-1:0] bank_wins;

  for (genvar s = 0; s < 2; s++) begin : g_bank
    bat_bank #(.N_ENT(N_ENT), .SIDE(s[0])) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .side  (cfg_dside),
      .idx   (cfg_idx),
      .wdata (wdata),
      .wins  (bank_wins[s])
    );
  end

  bat_win_t [N_ENT-1:0] sel_wins;
  assign sel_wins = bank_wins[req_dside];

  logic [N_ENT-1:0] lk_qual;
  logic [N_ENT-1:0] lk_win;
  logic             lk_hit;
  logic [AW-1:0]    lk_real;
  logic             lk_rd;
  logic             lk_wr;

  bat_search #(.N_ENT(N_ENT)) u_search (
    .wins      (sel_wins),
    .ea        (req_ea),
    .user      (req_user),
    .write     (req_write),
    .qual      (lk_qual),
    .win_oh    (lk_win),
    .hit       (lk_hit),
    .real_addr (lk_real),
    .rd        (lk_rd),
    .wr        (lk_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_real  <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= lk_hit;
        rsp_real <= lk_real;
        rsp_rd   <= lk_rd;
        rsp_wr   <= lk_wr;
        rsp_ex   <= lk_hit;
      end
    end
  end

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter int N_ENT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [N_ENT-1:0] lk_win,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [31:0]      rsp_real,
  input logic             rsp_rd,
  input logic             rsp_wr,
  input logic             rsp_ex
);

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_real) && $stable(rsp_rd)
                    && $stable(rsp_wr) && $stable(rsp_ex)));

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_real == '0 && !rsp_rd && !rsp_wr && !rsp_ex));

  p_rights_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_rd && rsp_ex));

  p_write_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && $past(req_write)) |-> rsp_wr);

  p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_win));

endmodule

bind bat_xlate_top bat_xlate_chk #(.N_ENT(N_ENT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .lk_win    (lk_win),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_real  (rsp_real),
  .rsp_rd    (rsp_rd),
  .rsp_wr    (rsp_wr),
  .rsp_ex    (rsp_ex)
);

// File: tb/tb_bat_xlate_top.sv
`timescale 1ns/1ps
module tb_bat_xlate_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_dside = 0;
  logic [2:0]  cfg_idx = 0;
  logic [31:0] cfg_ea_base = 0, cfg_ea_mask = 0, cfg_ra_base = 0;
  logic        cfg_sup_en = 0, cfg_usr_en = 0;
  logic [1:0]  cfg_prot = 0;
  logic        req_valid = 0, req_dside = 0, req_user = 0, req_write = 0;
  logic [31:0] req_ea = 0;
  logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_real;

  always #2.5 clk = ~clk;

  bat_xlate_top dut (.*);

  // behavioural reference: windows per set
  logic [31:0] m_base [2][8];
  logic [31:0] m_mask [2][8];
  logic [31:0] m_real [2][8];
  logic        m_sv   [2][8];
  logic        m_uv   [2][8];
  logic [1:0]  m_prot [2][8];

  logic        e_valid = 0, e_hit = 0, e_rd = 0, e_wr = 0, e_ex = 0;
  logic [31:0] e_real = 0;
  string       prev_tag = "R1";
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  task automatic compare();
    n_cmp++;
    if ({rsp_valid, rsp_hit, rsp_real, rsp_rd, rsp_wr, rsp_ex} !==
        {e_valid, e_hit, e_real, e_rd, e_wr, e_ex}) begin
      n_bad++;
      $display("FAIL %s: got v=%0b h=%0b ra=%h r=%0b w=%0b x=%0b, expected v=%0b h=%0b ra=%h r=%0b w=%0b x=%0b",
               prev_tag, rsp_valid, rsp_hit, rsp_real, rsp_rd, rsp_wr, rsp_ex,
               e_valid, e_hit, e_real, e_rd, e_wr, e_ex);
    end
  endtask

  task automatic model_lookup(logic [31:0] ea, logic d, logic u, logic w);
    int s;
    s = d ? 1 : 0;
    e_hit = 0; e_real = 0; e_rd = 0; e_wr = 0; e_ex = 0;
    for (int i = 0; i < 8; i++) begin
      if (!(u ? m_uv[s][i] : m_sv[s][i])) continue;
      if (((ea ^ m_base[s][i]) & m_mask[s][i]) != 0) continue;
      if (m_prot[s][i] == 2'd0) continue;
      if (w && m_prot[s][i] == 2'd1) continue;
      e_hit = 1;
      e_ex  = 1;
      e_rd  = 1;
      e_wr  = m_prot[s][i][1];
      e_real = m_real[s][i] | (ea ^ (ea & m_mask[s][i]));
      break;
    end
  endtask

  task automatic tick(logic we, logic wd, int wi, logic [31:0] wb, logic [31:0] wm,
                      logic [31:0] wr_, logic sv, logic uv, logic [1:0] pr,
                      logic rv, logic [31:0] ea, logic d, logic u, logic w, string tag);
    @(negedge clk);
    compare();
    cfg_we = we; cfg_dside = wd; cfg_idx = wi[2:0]; cfg_ea_base = wb; cfg_ea_mask = wm;
    cfg_ra_base = wr_; cfg_sup_en = sv; cfg_usr_en = uv; cfg_prot = pr;
    req_valid = rv; req_ea = ea; req_dside = d; req_user = u; req_write = w;
    if (rst_n) begin
      e_valid = rv;
      if (rv) model_lookup(ea, d, u, w);
      if (we) begin
        m_base[wd][wi] = wb; m_mask[wd][wi] = wm; m_real[wd][wi] = wr_;
        m_sv[wd][wi] = sv; m_uv[wd][wi] = uv; m_prot[wd][wi] = pr;
      end
    end
    prev_tag = tag;
  endtask

  task automatic wr_win(logic d, int i, logic [31:0] b, logic [31:0] m, logic [31:0] r,
                        logic sv, logic uv, logic [1:0] p, string tag);
    tick(1, d, i, b, m, r, sv, uv, p, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic req(logic [31:0] ea, logic d, logic u, logic w, string tag);
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ea, d, u, w, tag);
  endtask

  task automatic idle(string tag);
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        m_base[s][i] = 0; m_mask[s][i] = 0; m_real[s][i] = 0;
        m_sv[s][i] = 0; m_uv[s][i] = 0; m_prot[s][i] = 0;
      end
  end

  initial begin
    logic [31:0] seed;
    // R1: reset state, request during reset ignored
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h1234_5678, 0, 0, 0, "R1");
    idle("R1");
    idle("R1");
    rst_n = 1'b1;
    idle("R1");
    req(32'h0000_0000, 0, 0, 0, "R1");   // mask 0 base 0 but enables clear: miss
    req(32'h1234_5678, 1, 1, 0, "R1");
    idle("R10");
    // instruction window 0: 0x1xxxxxxx -> 0x8xxxxxxx, supervisor only, code 2
    wr_win(0, 0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 1, 0, 2'd2, "R11");
    // data window 0: same range -> 0x4xxxxxxx, both states, code 1
    wr_win(1, 0, 32'h1000_0000, 32'hF000_0000, 32'h4000_0000, 1, 1, 2'd1, "R11");
    req(32'h1234_5678, 0, 0, 0, "R5");
    req(32'h1234_5678, 1, 0, 0, "R2");
    req(32'h1234_5678, 0, 1, 0, "R3");   // user, supervisor-only window
    req(32'h1234_5678, 1, 1, 0, "R3");
    req(32'h1234_5678, 0, 0, 1, "R6");   // write allowed by code 2
    req(32'h1234_5678, 1, 0, 1, "R7");   // write refused by code 1 -> miss
    idle("R9");
    idle("R9");
    // data window 3 covers the same range with code 3
    wr_win(1, 3, 32'h1000_0000, 32'hF000_0000, 32'h5000_0000, 1, 1, 2'd3, "R11");
    req(32'h1abc_d123, 1, 0, 1, "R7");   // window 0 skipped, window 3 wins
    req(32'h1abc_d123, 1, 0, 0, "R8");   // read: window 0 wins
    // data window 1 code 0 on 0x2xxxxxxx, window 2 narrower code 2
    wr_win(1, 1, 32'h2000_0000, 32'hF000_0000, 32'h6000_0000, 1, 1, 2'd0, "R11");
    wr_win(1, 2, 32'h2340_0000, 32'hFFF0_0000, 32'h7770_0000, 1, 1, 2'd2, "R11");
    req(32'h2345_6789, 1, 0, 0, "R7");
    req(32'h2445_6789, 1, 0, 0, "R4");   // window 2 mismatch, window 1 refused: miss
    req(32'h2340_0000, 1, 1, 1, "R4");
    // instruction windows 4 and 5 overlap
    wr_win(0, 4, 32'h3000_0000, 32'hF000_0000, 32'h9000_0000, 1, 1, 2'd3, "R11");
    wr_win(0, 5, 32'h3000_0000, 32'hF000_0000, 32'hA000_0000, 1, 1, 2'd1, "R11");
    req(32'h3fff_ffff, 0, 1, 0, "R8");
    // rewrite window 4 disabled in the same cycle as a request: old contents
    tick(1, 0, 4, 32'h3000_0000, 32'hF000_0000, 32'h9000_0000, 0, 0, 2'd3,
         1, 32'h3000_1000, 0, 1, 0, "R11");
    req(32'h3000_1000, 0, 1, 0, "R11");  // now window 5
    req(32'h3000_1000, 0, 1, 1, "R7");   // window 5 read-only: miss
    idle("R9");
    // pseudo-random traffic
    seed = 32'h1357_9bdf;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ea;
      logic [1:0]  rg;
      seed = seed * 32'd1103515245 + 32'd12345;
      rg = seed[17:16];
      ea = {(rg == 0) ? 4'h1 : (rg == 1) ? 4'h2 : (rg == 2) ? 4'h3 : 4'h5, seed[27:0] ^ {seed[3:0], 24'h0}};
      if (seed[30:29] == 2'b00)
        idle("R9");
      else if (seed[31] && seed[9:8] == 2'b11)
        tick(1, seed[4], int'(seed[7:5]), {seed[13:10], 28'h0}, 32'hF000_0000,
             {seed[21:18], 28'h0}, seed[22], seed[23], seed[25:24],
             1, ea, seed[26], seed[28], seed[2], "R11");
      else
        req(ea, seed[26], seed[28], seed[2], "R8");
    end
    idle("R9");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule